// File: doc/BRIEF.md
# Floating-Point Exception Status and Error Signalling Unit

This unit holds the exception state of a floating-point coprocessor. It keeps six exception flags with one mask bit each, plus a summary error bit, and drives an active-low error line back to the host CPU. The execution datapath reports the exception conditions raised by each instruction on an event strobe, together with the instruction and operand addresses. The unit records only the highest-precedence condition of each event. If that condition is unmasked, it also latches both addresses and raises the error line.

Hardware reset deliberately leaves the unit in a noisy state. The invalid-operation flag and the summary bit are set and the invalid-operation mask is cleared, so the error line is active from the first cycle and signals that the coprocessor is present. Only the no-wait initialise command brings the unit to its quiet defaults. The clear-exceptions command drops the flags and the summary bit but keeps the mask settings. Software loads the masks through a control-word write port. The flags, summary and masks are always readable.

Top module: `fpx_status_unit`

## Requirements
- R1: During and after hardware reset, with no command applied, the flags read 6'b000001, the summary bit reads 1, the masks read 6'b111110 and err_n_o reads 0. Bit i of both the flag vector and the mask vector is exception i, in this order: 0 invalid, 1 denormal, 2 zero-divide, 3 overflow, 4 underflow, 5 precision.
- R2: The cycle after init_i, the flags are 0, the summary is 0, all masks are 1 and both pointer registers are 0.
- R3: The cycle after clrex_i (without init_i), the flags and the summary are 0, while the masks and both pointer registers keep their values.
- R4: An event whose recorded exception is masked sets only that flag. It leaves the summary bit and err_n_o unchanged.
- R5: An event whose recorded exception is unmasked sets that flag and the summary bit in the next cycle.
- R6: When an event reports several exceptions at once, only the lowest-numbered one (highest precedence) is recorded. Its mask alone decides whether the event counts as unmasked. An event with evt_valid_i low has no effect.
- R7: An unmasked event loads iptr_o and dptr_o with evt_iaddr_i and evt_daddr_i. A masked event leaves them unchanged.
- R8: Commands apply in this order of priority: init_i first, then clrex_i, then the event and the control-word write. clrex_i discards a control-word write in the same cycle. An event uses the masks as they stood before a control-word write in the same cycle.
- R9: err_n_o is the inverse of the summary bit, delayed by one clock.
- R10: Flags are sticky. Once set, a flag stays set until init_i or clrex_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| init_i | input | 1 | No-wait initialise command |
| clrex_i | input | 1 | Clear-exceptions command |
| cw_wr_i | input | 1 | Control-word (mask) write strobe |
| cw_mask_i | input | NUM_EXC | Mask values to load |
| evt_valid_i | input | 1 | Exception event strobe from the datapath |
| evt_exc_i | input | NUM_EXC | Exceptions raised by the instruction |
| evt_iaddr_i | input | AW | Address of the instruction |
| evt_daddr_i | input | AW | Address of its memory operand |
| flag_o | output | NUM_EXC | Exception flags |
| summary_o | output | 1 | Summary error bit |
| mask_o | output | NUM_EXC | Exception masks |
| iptr_o | output | AW | Latched instruction address |
| dptr_o | output | AW | Latched operand address |
| err_n_o | output | 1 | Active-low error output |

## Verification
The hardest case to reach is an event with several exceptions where the highest-precedence one is masked and a lower one is not. That event must leave the error line quiet and the pointers untouched. To reach it and every similar case, the bench sweeps all 64 mask settings against all 63 non-empty exception sets. Before each event it re-initialises the unit and loads the mask pattern through the control-word port. A separate directed sequence applies commands in the same cycle to expose the command ordering: init with clear, clear with a mask write, and an event with a mask write.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   // Exception positions; a lower index means higher precedence.
   typedef enum int unsigned {
      EXC_INVALID   = 0,
      EXC_DENORMAL  = 1,
      EXC_ZERODIV   = 2,
      EXC_OVERFLOW  = 3,
      EXC_UNDERFLOW = 4,
      EXC_PRECISION = 5
   } fpx_exc_e;

   localparam int unsigned FPX_NUM_EXC = 6;
   localparam int unsigned FPX_ADDR_W  = 32;
endpackage

// File: rtl/fpx_prio_pick.sv
module fpx_prio_pick #(
   parameter int unsigned N = 6
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o
);
   if (N < 2) begin : g_bad_n
      $error("fpx_prio_pick: N must be at least 2");
   end

   // Lowest set index wins.
   always_comb begin
      logic found;
      found   = 1'b0;
      grant_o = '0;
      for (int i = 0; i < N; i++) begin
         if (req_i[i] && !found) begin
            grant_o[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end
endmodule

// File: rtl/fpx_flag_regs.sv
module fpx_flag_regs #(
   parameter int unsigned N       = 6,
   parameter int unsigned INV_IDX = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init_i,
   input  logic         clrex_i,
   input  logic         cw_wr_i,
   input  logic [N-1:0] cw_mask_i,
   input  logic [N-1:0] hit_i,
   output logic [N-1:0] flag_o,
   output logic [N-1:0] mask_o,
   output logic         summary_o,
   output logic         unmasked_o
);
   localparam logic [N-1:0] INV_BIT = N'(1) << INV_IDX;

   if (INV_IDX >= N) begin : g_bad_idx
      $error("fpx_flag_regs: INV_IDX out of range");
   end

   assign unmasked_o = |(hit_i & ~mask_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o    <= INV_BIT;
         mask_o    <= ~INV_BIT;
         summary_o <= 1'b1;
      end else if (init_i) begin
         flag_o    <= '0;
         mask_o    <= '1;
         summary_o <= 1'b0;
      end else if (clrex_i) begin
         flag_o    <= '0;
         summary_o <= 1'b0;
      end else begin
         flag_o    <= flag_o | hit_i;
         summary_o <= summary_o | unmasked_o;
         if (cw_wr_i) begin
            mask_o <= cw_mask_i;
         end
      end
   end

   logic pv;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pv <= 1'b0;
      else        pv <= 1'b1;
   end

   p_init_defaults_r2: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (flag_o == '0 && !summary_o && mask_o == '1));

   p_clrex_keeps_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clrex_i && !init_i) |=> (mask_o == $past(mask_o) && flag_o == '0));

   p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((|hit_i) && !unmasked_o && !summary_o && !init_i && !clrex_i) |=> !summary_o);

   p_one_new_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pv |-> ($countones(flag_o & ~$past(flag_o)) <= 1));

   p_sticky_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && !$past(init_i) && !$past(clrex_i)) |->
         ((flag_o & $past(flag_o)) == $past(flag_o)));
endmodule

// File: rtl/fpx_ptr_latch.sv
module fpx_ptr_latch #(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          cap_i,
   input  logic [AW-1:0] iaddr_i,
   input  logic [AW-1:0] daddr_i,
   output logic [AW-1:0] iptr_o,
   output logic [AW-1:0] dptr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iptr_o <= '0;
         dptr_o <= '0;
      end else if (clr_i) begin
         iptr_o <= '0;
         dptr_o <= '0;
      end else if (cap_i) begin
         iptr_o <= iaddr_i;
         dptr_o <= daddr_i;
      end
   end

   p_ptr_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_i && !clr_i) |=> (iptr_o == $past(iaddr_i) && dptr_o == $past(daddr_i)));
endmodule

// File: rtl/fpx_err_drive.sv
module fpx_err_drive (
   input  logic clk,
   input  logic rst_n,
   input  logic summary_i,
   output logic err_n_o
);
   // Reset value is the asserted level: presence indication.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_n_o <= 1'b0;
      else        err_n_o <= ~summary_i;
   end

   logic pv;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pv <= 1'b0;
      else        pv <= 1'b1;
   end

   p_err_tracks_summary_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pv |-> (err_n_o == !$past(summary_i)));
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit #(
   parameter int unsigned NUM_EXC = fpx_pkg::FPX_NUM_EXC,
   parameter int unsigned AW      = fpx_pkg::FPX_ADDR_W,
   parameter int unsigned INV_IDX = fpx_pkg::EXC_INVALID,
   parameter bit          PTR_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init_i,
   input  logic               clrex_i,
   input  logic               cw_wr_i,
   input  logic [NUM_EXC-1:0] cw_mask_i,
   input  logic               evt_valid_i,
   input  logic [NUM_EXC-1:0] evt_exc_i,
   input  logic [AW-1:0]      evt_iaddr_i,
   input  logic [AW-1:0]      evt_daddr_i,
   output logic [NUM_EXC-1:0] flag_o,
   output logic               summary_o,
   output logic [NUM_EXC-1:0] mask_o,
   output logic [AW-1:0]      iptr_o,
   output logic [AW-1:0]      dptr_o,
   output logic               err_n_o
);
   if (NUM_EXC < 2 || NUM_EXC > 16) begin : g_bad_num
      $error("fpx_status_unit: NUM_EXC must be 2..16");
   end
   if (AW < 1) begin : g_bad_aw
      $error("fpx_status_unit: AW must be positive");
   end

   logic [NUM_EXC-1:0] req;
   logic [NUM_EXC-1:0] hit;
   logic               unmasked;
   logic               cap;

   assign req = evt_valid_i ? evt_exc_i : '0;

   fpx_prio_pick #(.N(NUM_EXC)) u_pick (
      .req_i   (req),
      .grant_o (hit)
   );

   fpx_flag_regs #(.N(NUM_EXC), .INV_IDX(INV_IDX)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_i     (init_i),
      .clrex_i    (clrex_i),
      .cw_wr_i    (cw_wr_i),
      .cw_mask_i  (cw_mask_i),
      .hit_i      (hit),
      .flag_o     (flag_o),
      .mask_o     (mask_o),
      .summary_o  (summary_o),
      .unmasked_o (unmasked)
   );

   assign cap = unmasked && !init_i && !clrex_i;

   if (PTR_EN) begin : g_ptr
      fpx_ptr_latch #(.AW(AW)) u_ptr (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_i   (init_i),
         .cap_i   (cap),
         .iaddr_i (evt_iaddr_i),
         .daddr_i (evt_daddr_i),
         .iptr_o  (iptr_o),
         .dptr_o  (dptr_o)
      );
   end else begin : g_no_ptr
      assign iptr_o = '0;
      assign dptr_o = '0;
   end

   fpx_err_drive u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .summary_i (summary_o),
      .err_n_o   (err_n_o)
   );

   p_unmasked_sets_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> summary_o);
endmodule

// File: tb/fpx_status_unit_bench.sv
module fpx_status_unit_bench;
   localparam int unsigned N  = 6;
   localparam int unsigned AW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          init_i, clrex_i, cw_wr_i, evt_valid_i;
   logic [N-1:0]  cw_mask_i, evt_exc_i;
   logic [AW-1:0] evt_iaddr_i, evt_daddr_i;
   logic [N-1:0]  flag_o, mask_o;
   logic          summary_o, err_n_o;
   logic [AW-1:0] iptr_o, dptr_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   fpx_status_unit #(.NUM_EXC(N), .AW(AW)) u_fpx_status_unit (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .clrex_i(clrex_i),
      .cw_wr_i(cw_wr_i), .cw_mask_i(cw_mask_i), .evt_valid_i(evt_valid_i),
      .evt_exc_i(evt_exc_i), .evt_iaddr_i(evt_iaddr_i), .evt_daddr_i(evt_daddr_i),
      .flag_o(flag_o), .summary_o(summary_o), .mask_o(mask_o),
      .iptr_o(iptr_o), .dptr_o(dptr_o), .err_n_o(err_n_o)
   );

   task automatic chk(input string tag, input string what,
                      input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic quiet();
      init_i = 0; clrex_i = 0; cw_wr_i = 0; cw_mask_i = '0;
      evt_valid_i = 0; evt_exc_i = '0; evt_iaddr_i = '0; evt_daddr_i = '0;
   endtask

   // Called at a falling edge with inputs set; returns at the next falling edge.
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_init();
      quiet(); init_i = 1; tick(); quiet();
   endtask

   task automatic load_mask(input logic [N-1:0] m);
      quiet(); cw_wr_i = 1; cw_mask_i = m; tick(); quiet();
   endtask

   task automatic event_in(input logic [N-1:0] e, input logic [AW-1:0] ia,
                           input logic [AW-1:0] da);
      quiet(); evt_valid_i = 1; evt_exc_i = e; evt_iaddr_i = ia; evt_daddr_i = da;
      tick(); quiet();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [N-1:0]  pick;
      logic          es_exp;
      logic [AW-1:0] ia, da;
      quiet();
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk("R1", "flags in reset", AW'(flag_o), 32'h01);
      chk("R1", "masks in reset", AW'(mask_o), 32'h3E);
      chk("R1", "summary in reset", AW'(summary_o), 32'h1);
      chk("R1", "err_n in reset", AW'(err_n_o), 32'h0);
      rst_n = 1;
      tick(); tick();
      chk("R1", "flags after reset", AW'(flag_o), 32'h01);
      chk("R1", "masks after reset", AW'(mask_o), 32'h3E);
      chk("R1", "err_n after reset", AW'(err_n_o), 32'h0);

      do_init();
      chk("R2", "flags after init", AW'(flag_o), 32'h0);
      chk("R2", "summary after init", AW'(summary_o), 32'h0);
      chk("R2", "masks after init", AW'(mask_o), 32'h3F);
      chk("R2", "iptr after init", iptr_o, 32'h0);
      chk("R9", "err_n lags summary", AW'(err_n_o), 32'h0);
      tick();
      chk("R9", "err_n released after init", AW'(err_n_o), 32'h1);

      // Sweep: every mask pattern against every non-empty exception set.
      for (int m = 0; m < 64; m++) begin
         for (int f = 1; f < 64; f++) begin
            do_init();
            load_mask(N'(m));
            ia = 32'h1000_0000 | (m << 8) | f;
            da = 32'h2000_0000 | (f << 8) | m;
            event_in(N'(f), ia, da);
            pick = N'(f & -f);
            es_exp = ((pick & ~N'(m)) != 0);
            chk("R6", "recorded flag", AW'(flag_o), AW'(pick));
            chk(es_exp ? "R5" : "R4", "summary", AW'(summary_o), AW'(es_exp));
            chk("R7", "iptr", iptr_o, es_exp ? ia : 32'h0);
            chk("R7", "dptr", dptr_o, es_exp ? da : 32'h0);
            chk("R9", "err_n before lag", AW'(err_n_o), 32'h1);
            tick();
            chk(es_exp ? "R9" : "R4", "err_n after lag", AW'(err_n_o), AW'(!es_exp));
         end
      end

      // Sticky flags, masked event keeps pointers.
      do_init();
      load_mask(6'b111011);
      event_in(6'b000100, 32'hAAAA_0001, 32'hBBBB_0001);
      event_in(6'b100000, 32'hCCCC_0002, 32'hDDDD_0002);
      chk("R10", "sticky flags", AW'(flag_o), 32'h24);
      chk("R7", "iptr kept on masked", iptr_o, 32'hAAAA_0001);
      chk("R7", "dptr kept on masked", dptr_o, 32'hBBBB_0001);
      // Invalid strobe: no effect.
      quiet(); evt_exc_i = 6'b000001; tick(); quiet();
      chk("R6", "event without strobe", AW'(flag_o), 32'h24);
      chk("R6", "summary without strobe", AW'(summary_o), 32'h1);

      // Clear exceptions.
      quiet(); clrex_i = 1; tick(); quiet();
      chk("R3", "flags after clear", AW'(flag_o), 32'h0);
      chk("R3", "summary after clear", AW'(summary_o), 32'h0);
      chk("R3", "masks after clear", AW'(mask_o), 32'h3B);
      chk("R3", "iptr after clear", iptr_o, 32'hAAAA_0001);
      tick();
      chk("R9", "err_n after clear", AW'(err_n_o), 32'h1);

      // Command ordering.
      event_in(6'b000001, 32'h1, 32'h2);
      quiet(); init_i = 1; clrex_i = 1; cw_wr_i = 1; cw_mask_i = '0; tick(); quiet();
      chk("R8", "init wins over write", AW'(mask_o), 32'h3F);
      chk("R8", "init clears pointers", iptr_o, 32'h0);
      quiet(); cw_wr_i = 1; cw_mask_i = '0; evt_valid_i = 1; evt_exc_i = 6'b000010;
      tick(); quiet();
      chk("R8", "event uses old mask", AW'(summary_o), 32'h0);
      chk("R8", "write lands with event", AW'(mask_o), 32'h0);
      chk("R8", "flag with write", AW'(flag_o), 32'h02);
      quiet(); clrex_i = 1; cw_wr_i = 1; cw_mask_i = 6'h3F; evt_valid_i = 1;
      evt_exc_i = 6'b000001; tick(); quiet();
      chk("R8", "clear drops write", AW'(mask_o), 32'h0);
      chk("R8", "clear drops event", AW'(flag_o), 32'h0);
      chk("R8", "clear drops summary", AW'(summary_o), 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule